// File: doc/BRIEF.md
# Power Sequencing Supervisor

This block is the supervisory controller of a multi-rail power-management device. It decides which regulators may run: two buck converters, one boost converter, two tracking regulators and the watchdog. It also drives the active-low system reset output. It moves through five states: power-on reset, disabled, active, fault and locked. The inputs that steer it are an internal-supply-good level, an input-supply threshold comparison, an enable event, the enable pin level, SPI command strobes and a retry-only configuration bit.

The monitors deliver their conditions already sorted into four flag groups. Warning flags raise a one-cycle interrupt request. Soft flags pulse the reset output low while the block stays active. Hard flags and thermal-shutdown flags move the block into a timed fault state with every rail off. The fault wait is longer when a thermal shutdown caused it. A saturating counter tracks faults that follow one another closely. When the third such fault times out and locking is allowed, the block latches in the locked state instead of retrying. The block emits register-clear strobes for the register file kept outside it.

Top module: `pwrseq_supervisor`

## Requirements
- R1: After reset the state code (`state_o`) is 0 (power-on reset), with all rail and watchdog enables low and `rst_out_n` low. The block stays there until `vin_above_th` is high, and then moves to the disabled state (code 1). An enable event has no effect in this state.
- R2: In the first cycle of every entry into the disabled state, `clr_all` is high for one cycle.
- R3: An enable event in the disabled state moves the block to the active state (code 2). In the active state `en_buck1` is high. On every entry into the active state, all five switchable enables turn on. While active, `spi_en_wr` loads `spi_en_data`, with bit 0 for buck2, bit 1 for boost1, bit 2 for tracker 1, bit 3 for tracker 2 and bit 4 for the watchdog.
- R4: `rst_out_n` is low in every state except active. After entry into the active state it stays low for T_RST cycles and then rises.
- R5: A soft flag in the active state, with no hard or thermal flag in the same cycle, gives a one-cycle `soft_rst_pulse` in the next cycle. `rst_out_n` is low during that pulse, and the block stays active.
- R6: A hard or thermal flag in the active state moves the block to the fault state (code 3) at the next edge. This wins over a soft flag in the same cycle, and no soft pulse is produced.
- R7: A warning flag in the active state gives a one-cycle `irq_pulse` in the next cycle, and the state does not change.
- R8: In the fault state all enables are off. The block returns to the active state T_FLT_SHORT+1 cycles after entry, or T_FLT_LONG+1 cycles after entry when a thermal flag caused the fault.
- R9: Each entry into the fault state increments a fault count that saturates at LOCK_AFTER. The count clears once the block has spent T_RST cycles in the active state. If the count equals LOCK_AFTER when the fault wait expires and `cfg_retry_only` is 0, the block goes to the locked state (code 4).
- R10: In the active state, `spi_goto_lock` moves the block to the locked state only when `cfg_retry_only` is 0. `spi_goto_dis` moves it to the disabled state only when `enable_pin` is low. Otherwise each command is ignored.
- R11: The block leaves the locked state only on an enable event, which takes it to the active state. In the locked state all enables and `rst_out_n` are low.
- R12: `clr_events` is high for one cycle on entry into the fault state. Entry into the locked state raises neither clear strobe.
- R13: A low `core_supply_ok` moves the block to the power-on-reset state at the next edge, whatever its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_supply_ok | input | 1 | Internal supply within limits |
| vin_above_th | input | 1 | Input supply above start threshold |
| enable_evt | input | 1 | Enable event strobe |
| enable_pin | input | 1 | Enable pin level |
| cfg_retry_only | input | 1 | 1 = never lock, always retry |
| spi_goto_dis | input | 1 | SPI command strobe: go to disabled |
| spi_goto_lock | input | 1 | SPI command strobe: go to locked |
| spi_en_wr | input | 1 | SPI write strobe for the switchable enables |
| spi_en_data | input | 5 | Switchable enable bits |
| soft_flags | input | N_SOFT | Soft-reset conditions |
| hard_flags | input | N_HARD | Hard-reset conditions (non-thermal) |
| tsd_flags | input | N_TSD | Thermal-shutdown conditions |
| warn_flags | input | N_WARN | Interrupt-only conditions |
| en_buck1 | output | 1 | Buck1 enable |
| en_buck2 | output | 1 | Buck2 enable |
| en_boost1 | output | 1 | Boost1 enable |
| en_trk1 | output | 1 | Tracker 1 enable |
| en_trk2 | output | 1 | Tracker 2 enable |
| en_wdog | output | 1 | Watchdog enable |
| rst_out_n | output | 1 | Active-low system reset |
| soft_rst_pulse | output | 1 | Soft-reset pulse |
| irq_pulse | output | 1 | Interrupt request pulse |
| clr_all | output | 1 | Clear-all-registers strobe |
| clr_events | output | 1 | Clear-event-registers strobe |
| state_o | output | 3 | Current state code |

## Verification
The assertions check the following on every cycle:
- the hold in power-on reset;
- the low reset output outside the active state;
- that a hard event beats a soft one and leads to the fault state;
- that a warning causes no state change;
- that all rails are off during a fault;
- that the locked state is held and is entered only at saturated count;
- the fall to power-on reset on a supply loss.

Only the bench scenarios can show the following:
- the exact lengths of the reset delay and of the two fault waits;
- the count clearing after a clean active period;
- the pin and configuration gating of the SPI commands;
- that the SPI enable write reaches the right rails.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_POR = 3'd0,
    ST_DIS = 3'd1,
    ST_ACT = 3'd2,
    ST_FLT = 3'd3,
    ST_LCK = 3'd4
  } pwr_state_e;

  localparam int SW_BITS = 5;
endpackage

// File: rtl/pwrseq_event_sort.sv
module pwrseq_event_sort #(
  parameter int N_SOFT = 6,
  parameter int N_HARD = 11,
  parameter int N_TSD  = 3,
  parameter int N_WARN = 6
) (
  input  logic [N_SOFT-1:0] soft_flags,
  input  logic [N_HARD-1:0] hard_flags,
  input  logic [N_TSD-1:0]  tsd_flags,
  input  logic [N_WARN-1:0] warn_flags,
  output logic              hard_any,
  output logic              thermal_any,
  output logic              soft_only,
  output logic              warn_any
);
  // the hard tier masks the soft tier
  always_comb begin
    thermal_any = |tsd_flags;
    hard_any    = (|hard_flags) | thermal_any;
    soft_only   = (|soft_flags) & ~hard_any;
    warn_any    = |warn_flags;
  end
endmodule

// File: rtl/pwrseq_delay_timer.sv
module pwrseq_delay_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          cnt_en;

  assign cnt_en = restart | (cnt < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= restart ? '0 : cnt + 1'b1;
  end

  assign done = (cnt == limit);

  // count never runs past the active limit
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/pwrseq_supervisor.sv
module pwrseq_supervisor
  import pwrseq_pkg::*;
#(
  parameter int N_SOFT      = 6,
  parameter int N_HARD      = 11,
  parameter int N_TSD       = 3,
  parameter int N_WARN      = 6,
  parameter int T_RST       = 1000,
  parameter int T_FLT_SHORT = 500,
  parameter int T_FLT_LONG  = 4000,
  parameter int LOCK_AFTER  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                core_supply_ok,
  input  logic                vin_above_th,
  input  logic                enable_evt,
  input  logic                enable_pin,
  input  logic                cfg_retry_only,
  input  logic                spi_goto_dis,
  input  logic                spi_goto_lock,
  input  logic                spi_en_wr,
  input  logic [SW_BITS-1:0]  spi_en_data,
  input  logic [N_SOFT-1:0]   soft_flags,
  input  logic [N_HARD-1:0]   hard_flags,
  input  logic [N_TSD-1:0]    tsd_flags,
  input  logic [N_WARN-1:0]   warn_flags,
  output logic                en_buck1,
  output logic                en_buck2,
  output logic                en_boost1,
  output logic                en_trk1,
  output logic                en_trk2,
  output logic                en_wdog,
  output logic                rst_out_n,
  output logic                soft_rst_pulse,
  output logic                irq_pulse,
  output logic                clr_all,
  output logic                clr_events,
  output logic [2:0]          state_o
);
  localparam int T_MAX = (T_RST > T_FLT_LONG) ?
                         ((T_RST > T_FLT_SHORT) ? T_RST : T_FLT_SHORT) :
                         ((T_FLT_LONG > T_FLT_SHORT) ? T_FLT_LONG : T_FLT_SHORT);
  localparam int CW  = $clog2(T_MAX + 1);
  localparam int FCW = $clog2(LOCK_AFTER + 1);

  pwr_state_e         state, nxt;
  logic               hard_any, thermal_any, soft_only, warn_any;
  logic               tmr_done, tmr_restart;
  logic [CW-1:0]      tmr_limit;
  logic [FCW-1:0]     fault_cnt;
  logic               fcnt_inc, fcnt_clr, fcnt_en;
  logic               tsd_cause, enter_flt;
  logic [SW_BITS-1:0] sw_en;
  logic               sw_load_all, sw_wr, sw_en_ce;
  logic               soft_q, irq_q, clr_all_q, clr_ev_q;
  logic               act;

  pwrseq_event_sort #(
    .N_SOFT(N_SOFT), .N_HARD(N_HARD), .N_TSD(N_TSD), .N_WARN(N_WARN)
  ) u_sort (
    .soft_flags (soft_flags),
    .hard_flags (hard_flags),
    .tsd_flags  (tsd_flags),
    .warn_flags (warn_flags),
    .hard_any   (hard_any),
    .thermal_any(thermal_any),
    .soft_only  (soft_only),
    .warn_any   (warn_any)
  );

  // next-state decision
  always_comb begin
    nxt = state;
    unique case (state)
      ST_POR: if (vin_above_th) nxt = ST_DIS;
      ST_DIS: if (enable_evt) nxt = ST_ACT;
      ST_ACT: begin
        if (hard_any)                             nxt = ST_FLT;
        else if (spi_goto_lock && !cfg_retry_only) nxt = ST_LCK;
        else if (spi_goto_dis && !enable_pin)      nxt = ST_DIS;
      end
      ST_FLT: if (tmr_done)
                nxt = (fault_cnt == FCW'(LOCK_AFTER) && !cfg_retry_only) ? ST_LCK : ST_ACT;
      ST_LCK: if (enable_evt) nxt = ST_ACT;
      default: nxt = ST_POR;
    endcase
    if (!core_supply_ok) nxt = ST_POR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_POR;
    else        state <= nxt;
  end

  // shared delay timer, restarted on every state change
  assign tmr_restart = (nxt != state);

  always_comb begin
    unique case (state)
      ST_ACT:  tmr_limit = CW'(T_RST);
      ST_FLT:  tmr_limit = tsd_cause ? CW'(T_FLT_LONG) : CW'(T_FLT_SHORT);
      default: tmr_limit = '0;
    endcase
  end

  pwrseq_delay_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(tmr_restart),
    .limit  (tmr_limit),
    .done   (tmr_done)
  );

  // consecutive-fault counter
  assign enter_flt = (state == ST_ACT) && (nxt == ST_FLT);
  assign fcnt_inc  = enter_flt && (fault_cnt != FCW'(LOCK_AFTER));
  assign fcnt_clr  = ((state == ST_ACT) && tmr_done) || (state == ST_POR);
  assign fcnt_en   = fcnt_inc | fcnt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_cnt <= '0;
    else if (fcnt_en) fault_cnt <= fcnt_inc ? fault_cnt + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tsd_cause <= 1'b0;
    else if (enter_flt) tsd_cause <= thermal_any;
  end

  // switchable enables
  assign sw_load_all = (state != ST_ACT) && (nxt == ST_ACT);
  assign sw_wr       = (state == ST_ACT) && spi_en_wr;
  assign sw_en_ce    = sw_load_all | sw_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_en <= '0;
    else if (sw_en_ce) sw_en <= sw_load_all ? '1 : spi_en_data;
  end

  // pulses and clear strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q    <= 1'b0;
      irq_q     <= 1'b0;
      clr_all_q <= 1'b0;
      clr_ev_q  <= 1'b0;
    end else begin
      soft_q    <= (state == ST_ACT) && (nxt == ST_ACT) && soft_only;
      irq_q     <= (state == ST_ACT) && warn_any;
      clr_all_q <= (nxt == ST_DIS) && (state != ST_DIS);
      clr_ev_q  <= (nxt == ST_FLT) && (state != ST_FLT);
    end
  end

  assign act            = (state == ST_ACT);
  assign en_buck1       = act;
  assign en_buck2       = act & sw_en[0];
  assign en_boost1      = act & sw_en[1];
  assign en_trk1        = act & sw_en[2];
  assign en_trk2        = act & sw_en[3];
  assign en_wdog        = act & sw_en[4];
  assign rst_out_n      = act & tmr_done & ~soft_q;
  assign soft_rst_pulse = soft_q;
  assign irq_pulse      = irq_q;
  assign clr_all        = clr_all_q;
  assign clr_events     = clr_ev_q;
  assign state_o        = state;

  assert_por_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POR && !vin_above_th) |=> state == ST_POR);

  assert_dis_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIS && $past(state) != ST_DIS) |-> clr_all);

  assert_rst_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ACT) |-> !rst_out_n);

  assert_soft_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (state == ST_ACT && !rst_out_n));

  assert_hard_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && hard_any && core_supply_ok) |=> (state == ST_FLT && !soft_rst_pulse));

  assert_warn_noexit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && warn_any && !hard_any && !spi_goto_lock && !spi_goto_dis
     && core_supply_ok) |=> state == ST_ACT);

  assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLT) |-> !(en_buck1 | en_buck2 | en_boost1 | en_trk1 | en_trk2 | en_wdog));

  assert_lock_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LCK && $past(state) == ST_FLT) |-> fault_cnt == FCW'(LOCK_AFTER));

  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LCK && !enable_evt && core_supply_ok) |=> state == ST_LCK);

  assert_fault_events_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLT && $past(state) == ST_ACT) |-> (clr_events && !clr_all));

  assert_supply_por_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !core_supply_ok |=> state == ST_POR);
endmodule

// File: tb/pwrseq_supervisor_test.sv
module pwrseq_supervisor_test;
  localparam int TR = 8;
  localparam int TS = 4;
  localparam int TL = 10;

  typedef struct packed {
    logic [1:0] kind;   // 0 warn, 1 soft, 2 hard, 3 thermal
    logic [3:0] idx;
    logic [2:0] st;
    logic       sft;
    logic       irq;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{2'd0, 4'd0,  3'd2, 1'b0, 1'b1},
    '{2'd0, 4'd5,  3'd2, 1'b0, 1'b1},
    '{2'd1, 4'd0,  3'd2, 1'b1, 1'b0},
    '{2'd1, 4'd4,  3'd2, 1'b1, 1'b0},
    '{2'd1, 4'd5,  3'd2, 1'b1, 1'b0},
    '{2'd2, 4'd0,  3'd3, 1'b0, 1'b0},
    '{2'd2, 4'd10, 3'd3, 1'b0, 1'b0},
    '{2'd3, 4'd0,  3'd3, 1'b0, 1'b0},
    '{2'd3, 4'd2,  3'd3, 1'b0, 1'b0},
    '{2'd0, 4'd3,  3'd2, 1'b0, 1'b1}
  };

  logic clk, rst_n, core_ok, vin_ok, en_evt, en_pin, cfg_ro;
  logic goto_dis, goto_lock, en_wr;
  logic [4:0]  en_data;
  logic [5:0]  soft_f;
  logic [10:0] hard_f;
  logic [2:0]  tsd_f;
  logic [5:0]  warn_f;
  logic b1, b2, bo, t1, t2, wd, rstn_o, sp, ip, ca, ce;
  logic [2:0] st;
  int total = 0;
  int bad = 0;

  pwrseq_supervisor #(
    .T_RST(TR), .T_FLT_SHORT(TS), .T_FLT_LONG(TL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .core_supply_ok(core_ok), .vin_above_th(vin_ok),
    .enable_evt(en_evt), .enable_pin(en_pin), .cfg_retry_only(cfg_ro),
    .spi_goto_dis(goto_dis), .spi_goto_lock(goto_lock), .spi_en_wr(en_wr),
    .spi_en_data(en_data), .soft_flags(soft_f), .hard_flags(hard_f),
    .tsd_flags(tsd_f), .warn_flags(warn_f), .en_buck1(b1), .en_buck2(b2),
    .en_boost1(bo), .en_trk1(t1), .en_trk2(t2), .en_wdog(wd), .rst_out_n(rstn_o),
    .soft_rst_pulse(sp), .irq_pulse(ip), .clr_all(ca), .clr_events(ce), .state_o(st)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rails();
    return {26'd0, wd, t2, t1, bo, b2, b1};
  endfunction

  task automatic pulse_evt();
    en_evt = 1'b1; step(); en_evt = 1'b0;
  endtask

  task automatic pulse_hard(input int i);
    hard_f[i] = 1'b1; step(); hard_f = '0;
  endtask

  // steps until the state differs from the fault state
  task automatic leave_fault(output int n);
    n = 0;
    while (st == 3'd3 && n < 100) begin step(); n++; end
  endtask

  task automatic settle();
    repeat (TR + 2) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; core_ok = 1; vin_ok = 0; en_evt = 0; en_pin = 1; cfg_ro = 1;
    goto_dis = 0; goto_lock = 0; en_wr = 0; en_data = '0;
    soft_f = '0; hard_f = '0; tsd_f = '0; warn_f = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 reset state", st, 0);
    chk("R1 rails off", rails(), 0);
    chk("R1 reset out low", rstn_o, 0);
    pulse_evt();
    repeat (3) step();
    chk("R1 hold without vin", st, 0);
    vin_ok = 1; step();
    chk("R1 to disabled", st, 1);
    chk("R2 clear all", ca, 1);
    step();
    chk("R2 clear one cycle", ca, 0);
    pulse_evt();
    chk("R3 active", st, 2);
    chk("R3 all rails on", rails(), 63);
    chk("R4 reset low at entry", rstn_o, 0);
    repeat (TR - 1) step();
    chk("R4 reset low before delay", rstn_o, 0);
    step();
    chk("R4 reset high after delay", rstn_o, 1);
    en_wr = 1; en_data = 5'b01010; step(); en_wr = 0;
    chk("R3 spi enables", rails(), 6'b010101);
    en_wr = 1; en_data = 5'b11111; step(); en_wr = 0;
    settle();

    // vector table
    foreach (TBL[k]) begin
      vec_t v = TBL[k];
      case (v.kind)
        2'd0: warn_f[v.idx] = 1'b1;
        2'd1: soft_f[v.idx] = 1'b1;
        2'd2: hard_f[v.idx] = 1'b1;
        default: tsd_f[v.idx] = 1'b1;
      endcase
      step();
      soft_f = '0; hard_f = '0; tsd_f = '0; warn_f = '0;
      chk("R5 R6 R7 state", st, v.st);
      chk("R5 soft pulse", sp, v.sft);
      chk("R7 irq pulse", ip, v.irq);
      if (v.kind == 2'd1) begin
        chk("R5 reset low in pulse", rstn_o, 0);
        step();
        chk("R5 pulse one cycle", rstn_o, 1);
      end else if (v.kind >= 2'd2) begin
        chk("R12 clear events", ce, 1);
        chk("R8 rails off", rails(), 0);
        leave_fault(n);
        chk("R8 fault wait", n, (v.kind == 2'd3) ? TL + 1 : TS + 1);
        chk("R3 rails back on", rails(), 63);
        settle();
      end else begin
        step();
        chk("R7 irq one cycle", ip, 0);
      end
    end

    // hard and soft in the same cycle
    hard_f[1] = 1'b1; soft_f[0] = 1'b1; step(); hard_f = '0; soft_f = '0;
    chk("R6 hard wins state", st, 3);
    chk("R6 no soft pulse", sp, 0);
    leave_fault(n);
    settle();

    // SPI lock gated by configuration
    goto_lock = 1; step(); goto_lock = 0;
    chk("R10 lock ignored", st, 2);
    cfg_ro = 0;
    goto_lock = 1; step(); goto_lock = 0;
    chk("R10 lock taken", st, 4);
    chk("R12 no clear on lock", ca | ce, 0);
    pulse_evt();
    chk("R11 unlock", st, 2);
    settle();

    // three close faults lead to lock
    for (int i = 0; i < 3; i++) begin
      pulse_hard(2);
      leave_fault(n);
      chk("R9 state after fault", st, (i == 2) ? 4 : 2);
    end
    chk("R12 no clear on lock", ca | ce, 0);
    chk("R11 rails off locked", rails(), 0);
    chk("R11 reset low locked", rstn_o, 0);
    repeat (5) step();
    chk("R11 held locked", st, 4);
    pulse_evt();
    chk("R11 leave locked", st, 2);
    settle();

    // clean active period clears the count
    pulse_hard(3); leave_fault(n);
    pulse_hard(3); leave_fault(n);
    settle();
    pulse_hard(3); leave_fault(n);
    chk("R9 count cleared", st, 2);
    settle();

    // SPI disable gated by pin
    goto_dis = 1; step(); goto_dis = 0;
    chk("R10 disable ignored", st, 2);
    en_pin = 0;
    goto_dis = 1; step(); goto_dis = 0;
    chk("R10 disable taken", st, 1);
    chk("R2 clear all again", ca, 1);
    pulse_evt();
    settle();

    // supply loss
    core_ok = 0; step();
    chk("R13 to por", st, 0);
    chk("R13 rails off", rails(), 0);
    core_ok = 1; vin_ok = 0;
    pulse_evt();
    chk("R1 event ignored in por", st, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule